// File: doc/BRIEF.md
# Byte-Register I2C Bus Master

This block drives a two-wire I2C bus as its only master, under the control of a small byte-wide register port. Software writes the target address with a direction bit, loads up to two outgoing data bytes and writes the control register with the go bit set. The engine then produces a START condition, the address byte, one or two data bytes with their acknowledge slots and a STOP condition. SCL and SDA are open-drain: each output is an enable that pulls its line low, and the pad releases the line otherwise.

Each transaction carries one or two data bytes, chosen by a length bit in the control register. The go bit stays set for the whole transfer and serves as the busy flag. A missing acknowledge from the target sets a sticky error flag, cuts the transfer short and still ends it with STOP. The error flag clears when the next transaction is launched. In a read, the received bytes land in two read-data registers. The register port is a plain write strobe with a combinational read path. It has no handshake, so software polls the busy bit and does not stall the engine.

Register offsets on `reg_sel`: 0 address/direction, 1 first transmit byte, 2 second transmit byte, 3 first received byte, 4 second received byte, 5 control/status. The control/status byte holds the length bit in bit 0, go/busy in bit 1 and the acknowledge error in bit 2. Its other bits read as 0.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, the control/status register and the second received-byte register read 0x00, and neither SCL nor SDA is pulled low.
- R2: Writing control/status with bit 1 set while idle starts a transaction. Bit 1 reads 1 until the transaction finishes and 0 afterwards.
- R3: After START, the first byte on SDA is the address register sent MSB first: the 7-bit device address in bits 7:1 and the direction in bit 0, where 1 means read.
- R4: Control/status bit 0 selects the length. A value of 1 transfers two data bytes and 0 transfers one. Without errors, a transaction has exactly 1 + length acknowledge slots.
- R5: In a write, the first transmit register and then, for length two, the second transmit register are sent MSB first.
- R6: In a read, the first received byte is stored at offset 3 and the second at offset 4. A read rejected at the address leaves both registers unchanged.
- R7: In a read, the master drives ACK (SDA low) after the first byte of a two-byte read and releases SDA (NACK) after the last byte.
- R8: If SDA is high in the acknowledge slot of the address or of a written byte, control/status bit 2 is set, no further data bytes are sent and a STOP follows.
- R9: Control/status bit 2 reads 0 once a new transaction has been launched.
- R10: While busy, writes to the address, transmit and control registers are ignored. The registers keep their values and the running transfer is unaffected.
- R11: Between START and STOP, SDA changes only while SCL is low. Every transaction ends with one STOP, and both lines are released when busy drops.
- R12: Each SCL period is 4 × QTR_CYC system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register offset for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the register at reg_sel (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest case to reach is a target that rejects one specific byte in the middle of a two-byte write. The engine must then abandon the second byte, still close the bus and flag the error, and the following launch must clear the flag. The bench's target model takes a per-transaction setting that names the byte it refuses to acknowledge. Random transactions draw this setting alongside the address, the direction and the length. Directed cases force the address rejection and the refusal of the first data byte, and another directed case writes all registers while the engine is busy.

// File: rtl/i2c_mstr_pkg.sv
`timescale 1ns/1ps
package i2c_mstr_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_ADDR = 3'd0;
  localparam logic [OFS_W-1:0] OFS_TX0  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_TX1  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_RX0  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_RX1  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_CTL  = 3'd5;

  localparam int CTL_LEN = 0;
  localparam int CTL_GO  = 1;
  localparam int CTL_NAK = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_BIT, SQ_STOP} sq_state_e;
endpackage

// File: rtl/i2c_qtr_tick.sv
`timescale 1ns/1ps
module i2c_qtr_tick #(
  parameter int QTR_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2c_regs.sv
`timescale 1ns/1ps
module i2c_regs
  import i2c_mstr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [OFS_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              done,
  input  logic              nak_set,
  input  logic              rx_we0,
  input  logic              rx_we1,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              go,
  output logic              busy,
  output logic              len2,
  output logic [BYTE_W-1:0] dev_byte,
  output logic [BYTE_W-1:0] tx0,
  output logic [BYTE_W-1:0] tx1
);
  logic              nak;
  logic [BYTE_W-1:0] rx0, rx1;

  assign go = wr && (sel == OFS_CTL) && wdata[CTL_GO] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_byte <= '0;
      tx0      <= '0;
      tx1      <= '0;
      len2     <= 1'b0;
    end else if (wr && !busy) begin
      case (sel)
        OFS_ADDR: dev_byte <= wdata;
        OFS_TX0:  tx0      <= wdata;
        OFS_TX1:  tx1      <= wdata;
        OFS_CTL:  len2     <= wdata[CTL_LEN];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      nak  <= 1'b0;
    end else begin
      if (go)        busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (go)           nak <= 1'b0;
      else if (nak_set) nak <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx0 <= '0;
      rx1 <= '0;
    end else begin
      if (rx_we0) rx0 <= rx_byte;
      if (rx_we1) rx1 <= rx_byte;
    end
  end

  always_comb begin
    case (sel)
      OFS_ADDR: rdata = dev_byte;
      OFS_TX0:  rdata = tx0;
      OFS_TX1:  rdata = tx1;
      OFS_RX0:  rdata = rx0;
      OFS_RX1:  rdata = rx1;
      OFS_CTL:  rdata = {5'b0, nak, busy, len2};
      default:  rdata = '0;
    endcase
  end

  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && sel == OFS_ADDR) |=> $stable(dev_byte)); // R10
  AST_NAK_CLEAR_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !nak); // R9
endmodule

// File: rtl/i2c_seq.sv
`timescale 1ns/1ps
module i2c_seq
  import i2c_mstr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tick,
  input  logic [BYTE_W-1:0] dev_byte,
  input  logic [BYTE_W-1:0] tx0,
  input  logic [BYTE_W-1:0] tx1,
  input  logic              len2,
  input  logic              sda_in,
  output logic              run,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic              nak_set,
  output logic              rx_we0,
  output logic              rx_we1,
  output logic [BYTE_W-1:0] rx_byte
);
  sq_state_e         st;
  logic [1:0]        ph;
  logic [3:0]        bitc;
  logic [1:0]        bytei;
  logic [BYTE_W-1:0] shreg;
  logic              sda_q;
  logic              drive_low;

  logic              rd;
  logic [1:0]        last_byte;
  logic [BYTE_W-1:0] cur_tx;
  logic              chk_ack;
  logic              ack_end;

  assign rd        = dev_byte[0];
  assign last_byte = len2 ? 2'd2 : 2'd1;
  assign cur_tx    = (bytei == 2'd2) ? tx1 : tx0;
  assign chk_ack   = (bytei == 2'd0) || !rd;
  assign ack_end   = (st == SQ_BIT) && tick && (ph == 2'd3) && (bitc == 4'd8);

  always_comb begin
    case (st)
      SQ_START: scl_oe = (ph == 2'd3);
      SQ_BIT:   scl_oe = !ph[1];
      SQ_STOP:  scl_oe = (ph == 2'd0);
      default:  scl_oe = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      SQ_START: drive_low = (ph != 2'd0);
      SQ_STOP:  drive_low = (ph != 2'd3);
      SQ_BIT: begin
        if (bitc == 4'd8)        drive_low = (bytei != 2'd0) && rd && (bytei != last_byte);
        else if (bytei == 2'd0)  drive_low = !dev_byte[~bitc[2:0]];
        else if (rd)             drive_low = 1'b0;
        else                     drive_low = !cur_tx[~bitc[2:0]];
      end
      default:  drive_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b0;
    else        sda_q <= drive_low;
  end
  assign sda_oe = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      ph    <= '0;
      bitc  <= '0;
      bytei <= '0;
      shreg <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (go) begin
          st    <= SQ_START;
          ph    <= '0;
          bitc  <= '0;
          bytei <= '0;
        end
        SQ_START: if (tick) begin
          if (ph == 2'd3) begin
            st <= SQ_BIT;
            ph <= '0;
          end else ph <= ph + 2'd1;
        end
        SQ_BIT: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            if (bitc != 4'd8) begin
              if (bytei != 2'd0 && rd) shreg <= {shreg[BYTE_W-2:0], sda_in};
              bitc <= bitc + 4'd1;
            end else begin
              bitc <= '0;
              if ((chk_ack && sda_in) || bytei == last_byte) st <= SQ_STOP;
              else bytei <= bytei + 2'd1;
            end
          end
        end
        SQ_STOP: if (tick) begin
          if (ph == 2'd3) st <= SQ_IDLE;
          else            ph <= ph + 2'd1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign run     = (st != SQ_IDLE);
  assign done    = (st == SQ_STOP) && tick && (ph == 2'd3);
  assign nak_set = ack_end && chk_ack && sda_in;
  assign rx_we0  = ack_end && rd && (bytei == 2'd1);
  assign rx_we1  = ack_end && rd && (bytei == 2'd2);
  assign rx_byte = shreg;

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_BIT && $past(st == SQ_BIT) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R11
  AST_LAST_READ_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_BIT && $past(st == SQ_BIT) && ph == 2'd2 && bitc == 4'd8 && rd && bytei == last_byte) |-> !sda_oe); // R7
endmodule

// File: rtl/i2c_reg_master.sv
`timescale 1ns/1ps
module i2c_reg_master
  import i2c_mstr_pkg::*;
#(
  parameter int QTR_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic              go, busy, len2, tick, run, done, nak_set, rx_we0, rx_we1;
  logic [BYTE_W-1:0] dev_byte, tx0, tx1, rx_byte;

  i2c_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .done(done), .nak_set(nak_set), .rx_we0(rx_we0),
    .rx_we1(rx_we1), .rx_byte(rx_byte), .go(go), .busy(busy), .len2(len2),
    .dev_byte(dev_byte), .tx0(tx0), .tx1(tx1)
  );

  i2c_qtr_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  i2c_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick), .dev_byte(dev_byte),
    .tx0(tx0), .tx1(tx1), .len2(len2), .sda_in(sda_in), .run(run),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .nak_set(nak_set),
    .rx_we0(rx_we0), .rx_we1(rx_we1), .rx_byte(rx_byte)
  );

  AST_BUS_FREE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe)); // R11
  AST_BUSY_MEANS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> run); // R2
endmodule

// File: tb/i2c_reg_master_test.sv
`timescale 1ns/1ps
module i2c_reg_master_test;
  localparam int QTR = 5;
  localparam logic [2:0] A_ADDR = 3'd0, A_TX0 = 3'd1, A_TX1 = 3'd2,
                         A_RX0 = 3'd3, A_RX1 = 3'd4, A_CTL = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe;
  logic       slv_pull = 1'b0;
  wire        scl_line = ~scl_oe;
  wire        sda_line = ~(sda_oe | slv_pull);

  i2c_reg_master #(.QTR_CYC(QTR)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // target model state
  int pos = -1, byten = 0, nack_at = -1, exp_len = 1;
  int starts = 0, stops = 0, slots = 0, cyc = 0, last_rise = 0, period = 0;
  bit dead = 0;
  logic [7:0] rdb [0:1];
  logic [7:0] cap [0:2];
  logic mack [1:2];
  logic ps = 1'b1, pd = 1'b1;
  logic [7:0] exp_rx0 = 8'h00, exp_rx1 = 8'h00;

  always @(posedge clk) begin
    logic p;
    cyc++;
    p = 1'b0;
    if (ps && scl_line && pd && !sda_line) begin
      starts++; pos = -1; byten = 0; dead = 0; slots = 0; last_rise = 0;
      slv_pull <= 1'b0;
    end else if (ps && scl_line && !pd && sda_line) begin
      stops++;
      slv_pull <= 1'b0;
    end else if (!ps && scl_line) begin
      if (pos == 1 && last_rise != 0) period = cyc - last_rise;
      last_rise = cyc;
      if (pos >= 0 && pos < 8 && byten <= 2 && (byten == 0 || !cap[0][0]))
        cap[byten] = {cap[byten][6:0], sda_line};
      if (pos == 8) begin
        slots++;
        if (byten >= 1 && byten <= 2 && cap[0][0]) mack[byten] = sda_line;
      end
    end else if (ps && !scl_line) begin
      pos++;
      if (pos == 9) begin pos = 0; byten++; end
      if (!dead) begin
        if (pos == 8 && (byten == 0 || !cap[0][0])) begin
          if (nack_at == byten) dead = 1; else p = 1'b1;
        end else if (pos < 8 && byten >= 1 && byten <= exp_len && cap[0][0] &&
                     !(byten == 2 && mack[1] === 1'b1))
          p = ~rdb[byten-1][7-pos];
      end
      slv_pull <= p;
    end
    ps = scl_line;
    pd = sda_line;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    #2;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 8000; i++) begin
      rd_reg(A_CTL, v);
      if (!v[1]) break;
    end
  endtask

  function automatic bit exp_err(input bit rd, input int nk, input int len);
    return (nk == 0) || (!rd && nk >= 1 && nk <= len);
  endfunction

  function automatic int exp_slots(input bit rd, input int nk, input int len);
    if (nk == 0) return 1;
    if (!rd && nk >= 1 && nk <= len) return 1 + nk;
    return 1 + len;
  endfunction

  task automatic run_txn(input logic [6:0] a, input bit rd, input bit two,
                         input logic [7:0] t0, input logic [7:0] t1,
                         input logic [7:0] r0, input logic [7:0] r1, input int nk);
    logic [7:0] v;
    int s0, len;
    len = two ? 2 : 1;
    nack_at = nk; exp_len = len; rdb[0] = r0; rdb[1] = r1;
    cap[0] = 8'h00; cap[1] = 8'h00; cap[2] = 8'h00;
    mack[1] = 1'bx; mack[2] = 1'bx;
    wr_reg(A_ADDR, {a, rd});
    wr_reg(A_TX0, t0);
    wr_reg(A_TX1, t1);
    s0 = stops;
    wr_reg(A_CTL, {6'b0, 1'b1, two});
    rd_reg(A_CTL, v);
    check("R2 busy bit after launch", {7'b0, v[1]}, 8'h01);
    check("R9 error flag cleared at launch", {7'b0, v[2]}, 8'h00);
    wait_idle();
    rd_reg(A_CTL, v);
    check("R2 R4 R8 control/status after done", v,
          {5'b0, exp_err(rd, nk, len), 1'b0, two});
    check("R3 address byte on bus", cap[0], {a, rd});
    check("R4 R8 acknowledge slot count", 8'(slots), 8'(exp_slots(rd, nk, len)));
    check("R11 one STOP per transaction", 8'(stops - s0), 8'h01);
    if (!rd && nk != 0) begin
      check("R5 first written byte", cap[1], t0);
      if (two && nk != 1) check("R5 second written byte", cap[2], t1);
    end
    if (rd && nk != 0) begin
      exp_rx0 = r0;
      if (two) begin
        exp_rx1 = r1;
        check("R7 master ACK after first of two", {7'b0, mack[1]}, 8'h00);
        check("R7 master NACK after last", {7'b0, mack[2]}, 8'h01);
      end else begin
        check("R7 master NACK after single byte", {7'b0, mack[1]}, 8'h01);
      end
    end
    rd_reg(A_RX0, v);
    check("R6 first received byte", v, exp_rx0);
    rd_reg(A_RX1, v);
    check("R6 second received byte", v, exp_rx1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=busy expected=idle");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd_reg(A_CTL, v); check("R1 control/status reset", v, 8'h00);
    rd_reg(A_RX1, v); check("R1 second received byte reset", v, 8'h00);
    check("R1 lines released", {6'b0, scl_line, sda_line}, 8'h03);

    run_txn(7'h50, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'h00, 8'h00, -1);
    run_txn(7'h21, 1'b1, 1'b1, 8'h00, 8'h00, 8'h9E, 8'h61, -1);
    run_txn(7'h7F, 1'b1, 1'b0, 8'h00, 8'h00, 8'hC4, 8'hFF, -1);
    run_txn(7'h01, 1'b0, 1'b0, 8'h80, 8'h00, 8'h00, 8'h00, -1);
    run_txn(7'h33, 1'b0, 1'b1, 8'h11, 8'h22, 8'h00, 8'h00, 0);   // R8 address rejected
    run_txn(7'h33, 1'b1, 1'b1, 8'h00, 8'h00, 8'h5A, 8'hA5, 0);   // R6 rx kept
    run_txn(7'h44, 1'b0, 1'b1, 8'hF0, 8'h0F, 8'h00, 8'h00, 1);   // R8 second byte skipped
    run_txn(7'h44, 1'b0, 1'b1, 8'h12, 8'h34, 8'h00, 8'h00, -1);  // R9 after error

    check("R12 SCL period", 8'(period), 8'(4 * QTR));

    // R10: register writes during a transfer
    nack_at = -1; exp_len = 1;
    cap[0] = 8'h00; cap[1] = 8'h00; cap[2] = 8'h00;
    wr_reg(A_ADDR, {7'h2A, 1'b0});
    wr_reg(A_TX0, 8'hC3);
    wr_reg(A_CTL, 8'h02);
    wr_reg(A_ADDR, 8'h55);
    wr_reg(A_TX0, 8'h3C);
    wr_reg(A_CTL, 8'h03);
    rd_reg(A_ADDR, v); check("R10 address held while busy", v, 8'h54);
    rd_reg(A_TX0, v);  check("R10 transmit byte held while busy", v, 8'hC3);
    wait_idle();
    rd_reg(A_CTL, v);  check("R10 length bit held while busy", v, 8'h00);
    check("R10 transfer undisturbed", cap[1], 8'hC3);
    check("R10 slot count undisturbed", 8'(slots), 8'h02);

    for (int n = 0; n < 30; n++) begin
      logic [6:0] a;
      bit rd, two;
      int nk;
      a = 7'($urandom);
      rd = 1'($urandom);
      two = 1'($urandom);
      nk = ($urandom % 4 == 0) ? int'($urandom % 3) : -1;
      run_txn(a, rd, two, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), nk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule